// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port

This block moves one data word (eight bits by default) over a three-wire synchronous link: a data-out pin, a data-in pin and a clock pin. Software programs it through a small register window. A control register selects enable, bit order, master or slave role, clock idle level and one of four master bit rates. A status register carries a sticky transfer-complete flag. A data register holds the word to send, and after a transfer it holds the word received. When the port is disabled, the three pins belong to a plain general-purpose I/O port with its own output and direction registers.

As master, the block starts a transfer when the data register is written. It drives the clock from a divided system clock. As slave, it takes the clock from the pin and passes it through a synchronizer. In both roles, data leaves on the falling clock edge and is captured on the rising edge. Clearing the enable bit stops a transfer at once and zeroes the bit counter. Clearing the master bit does the same.

Top module: `sio_port`

## Requirements
- R1: After reset the control register (address 0) and status register (address 1) read 0, and all pins are undriven (`pin_oe` = 0, `pin_out` = 0).
- R2: Pin 0 is data out, pin 1 is data in and pin 2 is the clock. While the enable bit (control bit 0) is set, `pin_oe` reads 3'b101 in master mode and 3'b001 in slave mode, whatever is written to the GPIO registers. While enable is clear, `pin_out` equals the GPIO output register (address 3 write) and `pin_oe` equals the GPIO direction register (address 4).
- R3: Control bit 1 set sends and receives least-significant bit first. Clear, the order is most-significant bit first.
- R4: Control bit 2 selects master mode. With enable and master set, a write to the data register (address 2) starts a transfer. The flag reads set exactly 8×D cycles after the write edge, where D is 2, 4, 16 or 32 for rate code 3, 2, 1 or 0 (control bits 6:5).
- R5: The master clock is low for the first half of each bit period and high for the second. Data out changes only at falling edges. There are exactly eight rising edges per transfer. Between transfers the clock rests low when control bit 4 is 1 and high when it is 0.
- R6: The flag (status bit 7) sets at the end of a transfer and stays set. Writing control bit 3 as 1 clears it. Writing bit 3 as 0 leaves it set. Bit 3 always reads 0.
- R7: Clearing enable during a transfer aborts it: no flag is raised, the pins return to GPIO, and the next transfer runs full length with correct data.
- R8: Clearing the master bit during a master transfer aborts it. No flag is raised, and the next master transfer runs full length.
- R9: In slave mode the external clock goes through a two-flop synchronizer. Eight synchronized rising edges complete a transfer, set the flag and leave the received word in the data register.
- R10: After a master transfer, reading the data register returns the word captured from pin 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address: 0 control, 1 status, 2 data, 3 GPIO data, 4 GPIO direction |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| pin_in | input | 3 | Pin input levels |
| pin_out | output | 3 | Pin output levels |
| pin_oe | output | 3 | Pin output enables |

## Verification
Register writes take effect on the edge that samples `bus_wr`, so pin and readback checks sample at the next falling clock edge. In master mode the flag is due exactly 8×D edges after the write edge. The bench counts falling edges from that write until the flag reads set, and compares the count with 8×D. Master data bits are captured at each rising edge of the generated clock. In slave mode, the synchronizer and edge detector add up to three cycles of delay. The bench therefore holds each clock phase for six cycles, and reads the flag and data eight cycles after the last rising edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam int ADDR_W = 3;
   localparam int NPINS  = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
   localparam logic [ADDR_W-1:0] A_DATA  = 3'd2;
   localparam logic [ADDR_W-1:0] A_GPD   = 3'd3;
   localparam logic [ADDR_W-1:0] A_GPDIR = 3'd4;

   localparam int B_EN   = 0;
   localparam int B_LSB  = 1;
   localparam int B_MST  = 2;
   localparam int B_CLR  = 3;
   localparam int B_IDLO = 4;
   localparam int B_RATE = 5;
   localparam int B_FLAG = 7;

   typedef struct packed {
      logic [1:0] rate;
      logic       idle_low;
      logic       mst;
      logic       lsb;
      logic       en;
   } ctrl_t;
endpackage

// File: rtl/sio_regs.sv
module sio_regs #(
   parameter int DW = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [sio_pkg::ADDR_W-1:0] addr,
   input  logic                       wr_en,
   input  logic [DW-1:0]              wr_data,
   output sio_pkg::ctrl_t             ctrl,
   output logic                       flag_clr,
   output logic                       data_wr,
   output logic [sio_pkg::NPINS-1:0]  gp_out,
   output logic [sio_pkg::NPINS-1:0]  gp_dir
);
   import sio_pkg::*;

   logic wr_ctrl;
   assign wr_ctrl  = wr_en && (addr == A_CTRL);
   assign flag_clr = wr_ctrl && wr_data[B_CLR];
   assign data_wr  = wr_en && (addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         gp_out <= '0;
         gp_dir <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl.en       <= wr_data[B_EN];
            ctrl.lsb      <= wr_data[B_LSB];
            ctrl.mst      <= wr_data[B_MST];
            ctrl.idle_low <= wr_data[B_IDLO];
            ctrl.rate     <= wr_data[B_RATE+1:B_RATE];
         end
         if (wr_en && addr == A_GPD)   gp_out <= wr_data[NPINS-1:0];
         if (wr_en && addr == A_GPDIR) gp_dir <= wr_data[NPINS-1:0];
      end
   end
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
   parameter int DIV_R0 = 32,
   parameter int DIV_R1 = 16,
   parameter int DIV_R2 = 4,
   parameter int DIV_R3 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       abort,
   input  logic       stop,
   input  logic [1:0] rate,
   input  logic       idle_low,
   output logic       busy,
   output logic       sample_tick,
   output logic       bound_tick,
   output logic       sck
);
   localparam int CNT_W = $clog2(DIV_R0);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   div_sel;
   logic [CNT_W:0]   half;
   logic [CNT_W:0]   cnt_x;

   always_comb begin
      case (rate)
         2'd3:    div_sel = (CNT_W+1)'(DIV_R3);
         2'd2:    div_sel = (CNT_W+1)'(DIV_R2);
         2'd1:    div_sel = (CNT_W+1)'(DIV_R1);
         default: div_sel = (CNT_W+1)'(DIV_R0);
      endcase
   end

   assign half        = div_sel >> 1;
   assign cnt_x       = {1'b0, cnt};
   assign sample_tick = busy && (cnt_x == half - 1'b1);
   assign bound_tick  = busy && (cnt_x >= div_sel - 1'b1);
   assign sck         = busy ? (cnt_x >= half) : !idle_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (bound_tick) begin
            cnt <= '0;
            if (stop) busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sio_edge.sv
module sio_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_pin,
   input  logic din_pin,
   output logic rise,
   output logic fall,
   output logic din_s
);
   logic [STAGES-1:0] sck_q;
   logic [STAGES-1:0] din_q;
   logic              sck_prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sck_q[i] <= 1'b0;
            din_q[i] <= 1'b0;
         end else if (i == 0) begin
            sck_q[i] <= sck_pin;
            din_q[i] <= din_pin;
         end else begin
            sck_q[i] <= sck_q[(i == 0) ? 0 : i-1];
            din_q[i] <= din_q[(i == 0) ? 0 : i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_q[STAGES-1];
   end

   assign rise  = sck_q[STAGES-1] && !sck_prev;
   assign fall  = !sck_q[STAGES-1] && sck_prev;
   assign din_s = din_q[STAGES-1];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
   parameter int DW = 8,
   localparam int CW = $clog2(DW+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          lsb,
   input  logic          sample,
   input  logic          advance,
   input  logic          din,
   output logic [DW-1:0] shreg,
   output logic          tx_bit,
   output logic [CW-1:0] bit_cnt
);
   logic [DW-1:0] shifted;

   assign shifted = lsb ? {din, shreg[DW-1:1]} : {shreg[DW-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         tx_bit  <= 1'b0;
         bit_cnt <= '0;
      end else begin
         if (load) begin
            shreg  <= load_data;
            tx_bit <= lsb ? load_data[0] : load_data[DW-1];
         end else begin
            if (sample)  shreg  <= shifted;
            if (advance) tx_bit <= lsb ? shreg[0] : shreg[DW-1];
         end
         if (clear || load) bit_cnt <= '0;
         else if (sample)   bit_cnt <= bit_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sio_port.sv
module sio_port #(
   parameter int DW          = 8,
   parameter int DIV_R0      = 32,
   parameter int DIV_R1      = 16,
   parameter int DIV_R2      = 4,
   parameter int DIV_R3      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    bus_addr,
   input  logic          bus_wr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [2:0]    pin_in,
   output logic [2:0]    pin_out,
   output logic [2:0]    pin_oe
);
   import sio_pkg::*;
   localparam int CW = $clog2(DW+1);

   if (DW < 8) begin : g_bad_dw
      $error("sio_port: DW must be at least 8");
   end
   if (DIV_R3 < 2 || (DIV_R3 % 2) != 0 || (DIV_R2 % 2) != 0 ||
       (DIV_R1 % 2) != 0 || (DIV_R0 % 2) != 0) begin : g_bad_div
      $error("sio_port: dividers must be even and at least 2");
   end
   if (!(DIV_R0 >= DIV_R1 && DIV_R1 >= DIV_R2 && DIV_R2 >= DIV_R3)) begin : g_bad_ord
      $error("sio_port: rate code 0 must be the slowest");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sio_port: at least two synchronizer stages");
   end

   ctrl_t         ctl;
   logic          flag_clr, data_wr;
   logic [2:0]    gp_out, gp_dir;
   logic          mst_prev, flag_q;
   logic          m_busy, m_sample, m_bound, m_sck;
   logic          s_rise, s_fall, s_din;
   logic [DW-1:0] shreg;
   logic          tx_bit;
   logic [CW-1:0] bit_cnt;
   logic          en_w, mst_w;
   logic          abort_any, abort_run, start, load;
   logic          sample, advance, done, din_sel;
   logic          cnt_full, cnt_zero, cnt_last;

   assign en_w  = ctl.en;
   assign mst_w = ctl.mst;

   sio_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
      .wr_data(bus_wdata), .ctrl(ctl), .flag_clr(flag_clr),
      .data_wr(data_wr), .gp_out(gp_out), .gp_dir(gp_dir)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mst_prev <= 1'b0;
      else        mst_prev <= ctl.mst;
   end

   assign cnt_full  = (bit_cnt == CW'(DW));
   assign cnt_last  = (bit_cnt == CW'(DW-1));
   assign cnt_zero  = (bit_cnt == '0);
   assign abort_any = !ctl.en || (ctl.mst != mst_prev);
   assign abort_run = !ctl.en || !ctl.mst;
   assign start     = data_wr && ctl.en && ctl.mst && !m_busy;
   assign load      = data_wr && (ctl.mst ? !m_busy : cnt_zero);

   sio_clkgen #(
      .DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3)
   ) u_clk (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort_run),
      .stop(cnt_full), .rate(ctl.rate), .idle_low(ctl.idle_low),
      .busy(m_busy), .sample_tick(m_sample), .bound_tick(m_bound),
      .sck(m_sck)
   );

   sio_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .sck_pin(pin_in[2]), .din_pin(pin_in[1]),
      .rise(s_rise), .fall(s_fall), .din_s(s_din)
   );

   always_comb begin
      if (ctl.mst) begin
         sample  = m_sample && ctl.en;
         advance = m_bound && ctl.en && !cnt_full;
         done    = m_bound && ctl.en && cnt_full;
         din_sel = pin_in[1];
      end else begin
         sample  = s_rise && ctl.en;
         advance = s_fall && ctl.en && !cnt_zero;
         done    = s_rise && ctl.en && cnt_last;
         din_sel = s_din;
      end
   end

   sio_shifter #(.DW(DW)) u_shift (
      .clk(clk), .rst_n(rst_n), .clear(abort_any || done), .load(load),
      .load_data(bus_wdata), .lsb(ctl.lsb), .sample(sample),
      .advance(advance), .din(din_sel), .shreg(shreg), .tx_bit(tx_bit),
      .bit_cnt(bit_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (done)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   always_comb begin
      if (ctl.en) begin
         pin_out = {m_sck, 1'b0, tx_bit};
         pin_oe  = {ctl.mst, 1'b0, 1'b1};
      end else begin
         pin_out = gp_out;
         pin_oe  = gp_dir;
      end
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = DW'({1'b0, ctl.rate, ctl.idle_low, 1'b0,
                                   ctl.mst, ctl.lsb, ctl.en});
         A_STAT:  bus_rdata = DW'({flag_q, 7'd0});
         A_DATA:  bus_rdata = shreg;
         A_GPD:   bus_rdata = DW'(pin_in);
         A_GPDIR: bus_rdata = DW'(gp_dir);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
   parameter int DW = 8,
   localparam int CW = $clog2(DW+1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          mst,
   input logic          flag,
   input logic          flag_clr,
   input logic          done,
   input logic [CW-1:0] bit_cnt,
   input logic          m_busy,
   input logic          sck,
   input logic          dout
);
   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !flag_clr |=> flag);

   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !done |=> !flag);

   // R7
   abort_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> bit_cnt == '0);

   // R8
   mst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && $fell(mst) |=> !m_busy);

   // R5
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_busy && sck && $past(sck) |-> $stable(dout));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CW'(DW));
endmodule

bind sio_port sio_port_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_w), .mst(mst_w), .flag(flag_q),
   .flag_clr(flag_clr), .done(done), .bit_cnt(bit_cnt), .m_busy(m_busy),
   .sck(m_sck), .dout(tx_bit)
);

// File: tb/tb_sio_port.sv
module tb_sio_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] pin_in;
   logic [2:0] pin_out, pin_oe;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic       slave_mode = 1'b0;
   logic       tb_sck = 1'b1;
   logic       slv_din = 1'b0;
   logic       tb_lsb = 1'b0;
   logic [7:0] tb_rx = '0;
   logic [7:0] cap = '0;
   int         k = 0;
   int         rises = 0;
   logic       mon_on = 1'b0;
   int         r5_bad = 0;
   logic       prev_sck = 1'b0, prev_d = 1'b0;
   logic       m_din;

   // {control, transmit word, word driven back on pin 1}
   localparam logic [23:0] VEC [6] = '{
      24'h05_A5_3C, 24'h67_81_7E, 24'h55_0F_F0,
      24'h27_C3_1E, 24'h77_5A_99, 24'h45_FF_00 };

   assign m_din  = (k < 8) ? tb_rx[tb_lsb ? k : 7-k] : 1'b0;
   assign pin_in = {tb_sck, slave_mode ? slv_din : m_din, 1'b0};

   sio_port dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   always @(posedge pin_out[2]) begin
      if (mon_on) begin
         if (k < 8) cap[tb_lsb ? k : 7-k] = pin_out[0];
         k = k + 1;
         rises = rises + 1;
      end
   end

   always @(negedge clk) begin
      if (mon_on) begin
         if (pin_out[2] && prev_sck && pin_out[0] != prev_d) r5_bad++;
         prev_sck <= pin_out[2];
         prev_d   <= pin_out[0];
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic int div_of(input logic [1:0] r);
      case (r)
         2'd3: return 2;
         2'd2: return 4;
         2'd1: return 16;
         default: return 32;
      endcase
   endfunction

   // write control, transfer one word, return cycles until the flag reads set
   task automatic run_master(input logic [7:0] c, input logic [7:0] tx,
                             input logic [7:0] rx, output int n);
      logic [7:0] s;
      wr(3'd0, c);
      tb_lsb = c[1]; tb_rx = rx; k = 0; rises = 0; cap = '0; r5_bad = 0;
      prev_sck = pin_out[2]; prev_d = pin_out[0];
      mon_on = 1'b1;
      wr(3'd2, tx);
      n = 0;
      rd(3'd1, s);
      while (!s[7] && n < 2000) begin
         @(negedge clk);
         n++;
         rd(3'd1, s);
      end
      mon_on = 1'b0;
   endtask

   task automatic run_slave(input logic [7:0] c, input logic [7:0] tx,
                            input logic [7:0] rx);
      logic [7:0] s;
      slave_mode = 1'b1;
      tb_sck = c[4] ? 1'b0 : 1'b1;
      repeat (6) @(negedge clk);
      wr(3'd0, c | 8'h08);
      repeat (4) @(negedge clk);
      chk(pin_oe == 3'b001, "R2 slave pin_oe", pin_oe, 3'b001);
      cap = '0;
      wr(3'd2, tx);
      for (int b = 0; b < 8; b++) begin
         @(negedge clk);
         slv_din = rx[c[1] ? b : 7-b];
         if (!c[4]) tb_sck = 1'b0;
         repeat (6) @(negedge clk);
         cap[c[1] ? b : 7-b] = pin_out[0];
         tb_sck = 1'b1;
         repeat (6) @(negedge clk);
         if (c[4]) tb_sck = 1'b0;
      end
      repeat (8) @(negedge clk);
      rd(3'd1, s);
      chk(s[7] == 1'b1, "R9 slave flag", s[7], 1);
      rd(3'd2, s);
      chk(s == rx, "R9 slave received word", s, rx);
      chk(cap == tx, "R3 slave sent word", cap, tx);
      slave_mode = 1'b0;
   endtask

   initial begin
      logic [7:0] s, c, tx, rx;
      int n, d;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(3'd0, s); chk(s == 8'h00, "R1 control after reset", s, 0);
      rd(3'd1, s); chk(s == 8'h00, "R1 status after reset", s, 0);
      chk(pin_oe == 3'b000, "R1 pin_oe after reset", pin_oe, 0);
      chk(pin_out == 3'b000, "R1 pin_out after reset", pin_out, 0);

      // R2 disabled: pins follow GPIO registers
      wr(3'd3, 8'h03);
      wr(3'd4, 8'h06);
      chk(pin_out == 3'b011, "R2 gpio out", pin_out, 3'b011);
      chk(pin_oe == 3'b110, "R2 gpio dir", pin_oe, 3'b110);

      // R2 enabled: GPIO writes have no effect on the pins
      wr(3'd0, 8'h05);
      wr(3'd4, 8'h00);
      wr(3'd3, 8'h04);
      chk(pin_oe == 3'b101, "R2 master pin_oe", pin_oe, 3'b101);
      chk(pin_out[2] == 1'b1, "R2 master clock idle", pin_out[2], 1);
      chk(pin_out[0] == 1'b0, "R2 master dout", pin_out[0], 0);
      wr(3'd4, 8'h06);
      wr(3'd3, 8'h03);

      for (int v = 0; v < 6; v++) begin
         c = VEC[v][23:16]; tx = VEC[v][15:8]; rx = VEC[v][7:0];
         d = div_of(c[6:5]);
         wr(3'd0, c);
         chk(pin_out[2] == !c[4], "R5 idle level before", pin_out[2], !c[4]);
         run_master(c, tx, rx, n);
         chk(n == 8*d, "R4 completion cycles", n, 8*d);
         chk(rises == 8, "R5 rising edges", rises, 8);
         chk(r5_bad == 0, "R5 data stable while clock high", r5_bad, 0);
         chk(cap == tx, "R3 master sent word", cap, tx);
         rd(3'd2, s);
         chk(s == rx, "R10 master received word", s, rx);
         chk(pin_out[2] == !c[4], "R5 idle level after", pin_out[2], !c[4]);
         wr(3'd0, c | 8'h08);
         rd(3'd1, s);
         chk(s[7] == 1'b0, "R6 flag cleared", s[7], 0);
      end

      // R6 sticky flag, write 0 has no effect, bit 3 reads 0
      run_master(8'h65, 8'h3C, 8'hC3, n);
      repeat (10) @(negedge clk);
      rd(3'd1, s); chk(s[7] == 1'b1, "R6 flag sticky", s[7], 1);
      wr(3'd0, 8'h65);
      rd(3'd1, s); chk(s[7] == 1'b1, "R6 zero write no effect", s[7], 1);
      wr(3'd0, 8'h6D);
      rd(3'd0, s); chk(s == 8'h65, "R6 clear bit reads 0", s, 8'h65);
      rd(3'd1, s); chk(s[7] == 1'b0, "R6 flag cleared by strobe", s[7], 0);

      // R7 enable cleared mid-transfer
      wr(3'd0, 8'h05);
      wr(3'd2, 8'hF0);
      repeat (50) @(negedge clk);
      wr(3'd0, 8'h00);
      chk(pin_oe == 3'b110, "R7 pins back to gpio oe", pin_oe, 3'b110);
      chk(pin_out == 3'b011, "R7 pins back to gpio out", pin_out, 3'b011);
      repeat (300) @(negedge clk);
      rd(3'd1, s); chk(s[7] == 1'b0, "R7 no flag after abort", s[7], 0);
      run_master(8'h05, 8'h69, 8'hB4, n);
      chk(n == 256, "R7 full length after abort", n, 256);
      rd(3'd2, s); chk(s == 8'hB4, "R7 data after abort", s, 8'hB4);
      wr(3'd0, 8'h0D);

      // R8 master bit cleared mid-transfer
      wr(3'd0, 8'h45);
      wr(3'd2, 8'h33);
      repeat (10) @(negedge clk);
      wr(3'd0, 8'h41);
      repeat (100) @(negedge clk);
      rd(3'd1, s); chk(s[7] == 1'b0, "R8 no flag after abort", s[7], 0);
      chk(pin_oe[2] == 1'b0, "R8 clock released", pin_oe[2], 0);
      run_master(8'h45, 8'hE1, 8'h5A, n);
      chk(n == 32, "R8 full length after abort", n, 32);
      rd(3'd2, s); chk(s == 8'h5A, "R8 data after abort", s, 8'h5A);

      // R9 slave transfers, both idle levels and orders
      run_slave(8'h01, 8'h96, 8'h4D);
      run_slave(8'h13, 8'hB2, 8'h71);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule